// File: doc/BRIEF.md
# Full-Bridge PWM Direction Steering

This block drives the four switches of an H-bridge from a free-running PWM period timer. A prescaler divides the input clock into timer steps. The timer counts from zero up to a programmed period value. In each direction, one output stays on and the diagonally opposite output is switched by a duty-cycle compare. The two outputs of the other diagonal stay off.

A direction request may arrive at any moment. The block acts on it only at the last timer step of the current period. At that point the two steady outputs swap at once. Both switched outputs are then held off until the next period begins, and the new direction takes full effect from that period.

Period, duty and prescale values are captured at the end of each period, so writes made during a period cannot disturb it. A one-clock strobe marks the first clock of every period.

Top module: `fullbridge_steer`

## Requirements
- R1: With the applied direction forward (dirIn = 0), outA is 1, outD carries the modulation, and outB and outC are 0.
- R2: With the applied direction reverse (dirIn = 1), outC is 1, outB carries the modulation, and outA and outD are 0.
- R3: prescaleSel 00, 01 and 1x give a timer step of 4, 16 and 64 clocks. A period lasts (period + 1) steps. periodStart is 1 only during the first clock of each period.
- R4: The modulated output is 1 while the timer is below the captured duty. A duty of 0 keeps it at 0 for the whole period, and a duty above the period value keeps it at 1 for the whole period.
- R5: periodIn, dutyIn and prescaleSel are sampled only on the edge that ends a period. Changing them mid-period does not alter the current period.
- R6: If dirIn differs from the applied direction on the edge that starts the last timer step, then for that whole step outA and outC already show the new direction and outB and outD are 0. The new direction applies in full from the next period. For a period value of 0, the test is made on the edge that starts the period.
- R7: If dirIn equals the applied direction on that edge, no early switching occurs. A later change of dirIn within the same step has no effect until the next test.
- R8: No dead band is inserted: when the steady outputs swap, one falls and the other rises in the same clock.
- R9: After reset the direction is forward, outA and periodStart are 1, and outB, outC and outD are 0. The first period is a single 4-clock step with zero duty.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| periodIn | input | 8 | Last timer value of a period |
| dutyIn | input | 8 | Modulated-output on-time in timer steps |
| prescaleSel | input | 2 | Step size select: 00 = 4, 01 = 16, 1x = 64 clocks |
| dirIn | input | 1 | Requested direction, 0 forward, 1 reverse |
| outA | output | 1 | Steady drive, forward side |
| outB | output | 1 | Modulated drive, reverse side |
| outC | output | 1 | Steady drive, reverse side |
| outD | output | 1 | Modulated drive, forward side |
| periodStart | output | 1 | High for the first clock of each period |

## Verification
All outputs come straight from state registers, so each response is due in the clock that follows the edge that changed that state. A period-start strobe appears in the first clock after the ending edge. An early swap shows in the first clock of the last step. A duty transition appears in the first clock of the step whose timer value reaches the duty. The driver works out, from the values it has applied, the expected output vector for every clock of the coming period and queues it. The monitor pops one entry per clock at the falling edge, half a cycle away from where the state changes.

// File: rtl/fbs_pkg.sv
package fbs_pkg;

  typedef struct packed {
    logic tick;       // last clock of a timer step
    logic rollover;   // last clock of the period
    logic enterLast;  // edge into the last timer step (non-rollover)
  } pwmStrobe_t;

  function automatic int stepClocks(input logic [1:0] sel, input int baseDiv);
    case (sel)
      2'b00:   stepClocks = baseDiv;
      2'b01:   stepClocks = baseDiv * 4;
      default: stepClocks = baseDiv * 16;
    endcase
  endfunction

endpackage

// File: rtl/fbs_timer_ctrl.sv
module fbs_timer_ctrl #(
  parameter int PERIOD_W = 8,
  parameter int BASE_DIV = 4
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [PERIOD_W-1:0]    periodIn,
  input  logic [1:0]             prescaleSel,
  output logic [PERIOD_W-1:0]    timer,
  output fbs_pkg::pwmStrobe_t    strobe,
  output logic                   periodStart
);
  localparam int STEP_W = $clog2(BASE_DIV * 16);

  logic [STEP_W-1:0]   psCnt;
  logic [STEP_W-1:0]   psLast;
  logic [PERIOD_W-1:0] periodReg;
  logic [1:0]          selReg;
  logic                startQ;

  always_comb begin
    psLast           = STEP_W'(fbs_pkg::stepClocks(selReg, BASE_DIV) - 1);
    strobe.tick      = (psCnt == psLast);
    strobe.rollover  = strobe.tick && (timer == periodReg);
    strobe.enterLast = strobe.tick && !strobe.rollover && (periodReg != '0)
                       && (timer == periodReg - 1'b1);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      psCnt     <= '0;
      timer     <= '0;
      periodReg <= '0;
      selReg    <= 2'b00;
      startQ    <= 1'b1;
    end else if (strobe.rollover) begin
      psCnt     <= '0;
      timer     <= '0;
      periodReg <= periodIn;
      selReg    <= prescaleSel;
      startQ    <= 1'b1;
    end else if (strobe.tick) begin
      psCnt     <= '0;
      timer     <= timer + 1'b1;
      startQ    <= 1'b0;
    end else begin
      psCnt     <= psCnt + 1'b1;
      startQ    <= 1'b0;
    end
  end

  assign periodStart = startQ;

  a_r3_timer_bounded: assert property (@(posedge clk) disable iff (!rstN)
    timer <= periodReg);
  a_r3_prescale_bounded: assert property (@(posedge clk) disable iff (!rstN)
    psCnt <= psLast);
  a_r3_start_after_roll: assert property (@(posedge clk) disable iff (!rstN)
    strobe.rollover |=> (periodStart && timer == '0));
  a_r5_capture_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.rollover |=> ($stable(periodReg) && $stable(selReg)));

endmodule

// File: rtl/fbs_steer_dp.sv
module fbs_steer_dp #(
  parameter int PERIOD_W = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [PERIOD_W-1:0] dutyIn,
  input  logic [PERIOD_W-1:0] periodIn,
  input  logic                dirIn,
  input  logic [PERIOD_W-1:0] timer,
  input  fbs_pkg::pwmStrobe_t strobe,
  output logic                outA,
  output logic                outB,
  output logic                outC,
  output logic                outD
);
  logic [PERIOD_W-1:0] dutyReg;
  logic                curDir;   // 0 forward, 1 reverse
  logic                pendReg;  // swap scheduled for this last step
  logic                nextDir;
  logic                modOn;
  logic                steer;

  assign nextDir = curDir ^ pendReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dutyReg <= '0;
      curDir  <= 1'b0;
      pendReg <= 1'b0;
    end else if (strobe.rollover) begin
      dutyReg <= dutyIn;
      curDir  <= nextDir;
      // a zero-length period starts directly in its last step
      pendReg <= (periodIn == '0) && (dirIn != nextDir);
    end else if (strobe.enterLast) begin
      pendReg <= (dirIn != curDir);
    end
  end

  always_comb begin
    modOn = (timer < dutyReg);
    steer = nextDir;
    outA  = !steer;
    outC  = steer;
    outD  = !curDir && modOn && !pendReg;
    outB  = curDir && modOn && !pendReg;
  end

  a_r6_dir_at_boundary: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(curDir) |-> $past(strobe.rollover));
  a_r6_pend_only_last: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pendReg) |-> $past(strobe.enterLast || strobe.rollover));
  a_r6_swap_completes: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.rollover && pendReg) |=> (curDir != $past(curDir)));
  a_r4_zero_duty: assert property (@(posedge clk) disable iff (!rstN)
    (dutyReg == '0) |-> (!outB && !outD));
  a_r8_no_leg_short: assert property (@(posedge clk) disable iff (!rstN)
    !(outA && outB) && !(outC && outD));

endmodule

// File: rtl/fullbridge_steer.sv
module fullbridge_steer #(
  parameter int PERIOD_W = 8,
  parameter int BASE_DIV = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [PERIOD_W-1:0] periodIn,
  input  logic [PERIOD_W-1:0] dutyIn,
  input  logic [1:0]          prescaleSel,
  input  logic                dirIn,
  output logic                outA,
  output logic                outB,
  output logic                outC,
  output logic                outD,
  output logic                periodStart
);
  logic [PERIOD_W-1:0] timer;
  fbs_pkg::pwmStrobe_t strobe;

  fbs_timer_ctrl #(.PERIOD_W(PERIOD_W), .BASE_DIV(BASE_DIV)) uCtrl (
    .clk(clk), .rstN(rstN), .periodIn(periodIn), .prescaleSel(prescaleSel),
    .timer(timer), .strobe(strobe), .periodStart(periodStart)
  );

  fbs_steer_dp #(.PERIOD_W(PERIOD_W)) uSteer (
    .clk(clk), .rstN(rstN), .dutyIn(dutyIn), .periodIn(periodIn), .dirIn(dirIn),
    .timer(timer), .strobe(strobe),
    .outA(outA), .outB(outB), .outC(outC), .outD(outD)
  );

endmodule

// File: tb/tb_fullbridge_steer.sv
`timescale 1ns/1ps
module tb_fullbridge_steer;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [7:0] periodIn = '0;
  logic [7:0] dutyIn = '0;
  logic [1:0] prescaleSel = '0;
  logic dirIn = 1'b0;
  logic outA, outB, outC, outD, periodStart;

  fullbridge_steer dut (
    .clk(clk), .rstN(rstN), .periodIn(periodIn), .dutyIn(dutyIn),
    .prescaleSel(prescaleSel), .dirIn(dirIn), .outA(outA), .outB(outB),
    .outC(outC), .outD(outD), .periodStart(periodStart)
  );

  always #10 clk = ~clk;

  typedef struct {
    logic [4:0] vec;  // {A,B,C,D,start}
    string      tag;
  } expItem_t;

  expItem_t expQ[$];
  int  nChecks = 0;
  int  nFail = 0;
  bit  done = 0;

  // bench view of the applied state
  logic [1:0] curSel = 2'b00;
  int  curPer = 0;
  int  curDuty = 0;
  logic curDir = 1'b0;
  logic lastDirIn = 1'b0;
  bit  firstPeriod = 1;

  function automatic int stepOf(input logic [1:0] s);
    if (s == 2'b00) return 4;
    if (s == 2'b01) return 16;
    return 64;
  endfunction

  // monitor: one expected vector per clock, compared at the falling edge
  initial begin
    forever begin
      @(negedge clk);
      if (expQ.size() > 0) begin
        expItem_t it;
        logic [4:0] got;
        it  = expQ.pop_front();
        got = {outA, outB, outC, outD, periodStart};
        nChecks++;
        if (got !== it.vec) begin
          nFail++;
          $display("FAIL %s: ABCDS got %b expected %b at %0t", it.tag, got, it.vec, $time);
        end
      end
    end
  end

  // driver: called just after the edge that opens a period
  task automatic playPeriod(input logic [1:0] nSel, input int nPer, input int nDuty,
                            input logic dirChk, input bit lateToggle, input string tag);
    int stepClk;
    int len;
    int lastStart;
    bit pend;
    stepClk   = stepOf(curSel);
    len       = (curPer + 1) * stepClk;
    lastStart = curPer * stepClk;
    if (firstPeriod) pend = 0;
    else if (curPer == 0) pend = (lastDirIn != curDir);
    else pend = (dirChk != curDir);
    for (int i = 0; i < len; i++) begin
      expItem_t it;
      bit mod, p, st;
      string auto;
      mod = ((i / stepClk) < curDuty);
      p   = pend && (i >= lastStart);
      st  = curDir ^ p;
      it.vec = {~st, curDir & mod & ~p, st, ~curDir & mod & ~p, (i == 0)};
      if (p) auto = "R6";
      else if (i == 0) auto = "R3";
      else if (curDir) auto = "R2";
      else auto = "R1";
      it.tag = {tag, "/", auto};
      expQ.push_back(it);
    end
    // new values mid-period: must only apply from the next period (R5)
    periodIn    = nPer[7:0];
    dutyIn      = nDuty[7:0];
    prescaleSel = nSel;
    dirIn       = dirChk;
    if (lateToggle) begin
      repeat (lastStart + 1) @(posedge clk);
      #2 dirIn = ~dirIn;  // R7: inside last step, after the test edge
      repeat (len - lastStart - 1) @(posedge clk);
    end else begin
      repeat (len) @(posedge clk);
    end
    #2;
    curDir      = curDir ^ pend;
    curSel      = nSel;
    curPer      = nPer;
    curDuty     = nDuty;
    lastDirIn   = dirIn;
    firstPeriod = 0;
  endtask

  initial begin
    #400000;
    if (!done) begin
      nChecks++;
      nFail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rstN = 1'b1;
    playPeriod(2'b00, 5, 2, 1'b0, 0, "R9");        // reset period, 4 clocks, duty 0
    playPeriod(2'b00, 5, 2, 1'b0, 0, "R1 R7");     // forward, no change
    playPeriod(2'b01, 3, 0, 1'b1, 0, "R6 R8");     // change to reverse at last step
    playPeriod(2'b10, 2, 9, 1'b0, 0, "R2 R4 R6");  // reverse, duty 0, change back
    playPeriod(2'b00, 4, 3, 1'b0, 1, "R3 R4 R7");  // x64 step, full duty, late toggle
    playPeriod(2'b11, 0, 1, 1'b0, 1, "R5 R7");     // late toggle feeds zero-length test
    playPeriod(2'b00, 1, 1, 1'b1, 0, "R3 R6");     // period 0 with pending swap
    playPeriod(2'b00, 1, 1, 1'b1, 0, "R2");        // reverse steady
    repeat (2) @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

endmodule